// File: doc/BRIEF.md
# Register Rename Unit

This block sits in the decode stage of a single-issue pipeline that issues in order and lets results complete out of order. It translates the 32 architectural register numbers of each instruction into tags for a pool of 64 physical registers. This removes the false write-after-write and write-after-read conflicts between instructions. The unit keeps two pieces of state: a map from each architectural register to its current physical tag with a pending flag, and one bit per physical register that marks the register as free.

In each cycle the unit accepts at most one instruction. The instruction carries two source register numbers and an optional destination. The source lookups and the new destination tag are combinational in the same cycle. The destination tag is the lowest-numbered free physical register. The unit also returns the tag the destination was mapped to before. The commit stage keeps that tag and hands it back once the instruction retires, which returns the register to the free list. Writeback broadcasts a finished physical tag, and any map entry still pointing at that tag stops being pending. When no physical register is free, the unit raises a stall and changes nothing.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register N maps to physical register N for N from 0 to 31, and no entry is pending. Physical registers 32 to 63 are free, so the first allocation returns tag 32.
- R2: physA and physB give the current mapping of srcA and srcB. The lookup happens before the same instruction's destination is remapped, so a source equal to the destination returns the old tag.
- R3: A rename with a non-zero destination, when not stalled, returns on dstPhys the lowest-numbered free physical register. That register is no longer free from the next cycle on.
- R4: prevPhys gives the mapping that dstArch held before this cycle's rename.
- R5: After a rename, the destination maps to the new tag and reads as pending (pendA/pendB = 1).
- R6: A writeback (wbValid, wbTag) clears the pending flag of every entry mapped to wbTag from the next cycle on. A source lookup in the same cycle that finds wbTag already reads as not pending.
- R7: If a rename and a writeback of that entry's old tag happen in the same cycle, the rename wins: the entry takes the new tag and stays pending.
- R8: With no free physical register, a rename with a non-zero destination raises stall in the same cycle. The map and the free list are left unchanged.
- R9: freeValid returns freeTag to the free list from the next cycle on. The tag is not available for allocation in the cycle of the request.
- R10: Architectural register 0 is never renamed. A destination of 0 allocates nothing and never stalls. Source 0 always returns tag 0 and reads as not pending.
- R11: When renValid or dstValid is low, the unit changes no mapping and allocates no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| renValid | input | 1 | An instruction is presented for renaming |
| srcA | input | 5 | First source architectural register |
| srcB | input | 5 | Second source architectural register |
| dstValid | input | 1 | The instruction writes a destination |
| dstArch | input | 5 | Destination architectural register |
| physA | output | 6 | Physical tag of srcA |
| pendA | output | 1 | srcA value still in flight |
| physB | output | 6 | Physical tag of srcB |
| pendB | output | 1 | srcB value still in flight |
| dstPhys | output | 6 | Newly allocated destination tag |
| prevPhys | output | 6 | Prior mapping of dstArch |
| stall | output | 1 | No free physical register; rename refused |
| wbValid | input | 1 | A result is written back |
| wbTag | input | 6 | Physical tag of the written-back result |
| freeValid | input | 1 | Commit releases a physical register |
| freeTag | input | 6 | Physical tag to release |

## Verification
The lookup outputs physA, physB, pendA, pendB, dstPhys, prevPhys and stall respond in the same cycle as their inputs, with no register on the path. Every effect on state shows up only after the next rising edge: a new mapping, a pending flag set or cleared, a register taken from or returned to the free list. The bench changes inputs on the falling edge and compares all outputs three nanoseconds later, just before the rising edge. Its behavioural model advances on that rising edge, so every comparison of a state effect lands on the first cycle after the stimulus.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // strobes passed from control to datapath
  typedef struct packed {
    logic allocEn;   // take a free register and remap the destination
    logic wbEn;      // clear pending flags that match the writeback tag
    logic freeEn;    // return a tag to the free list
  } strobe_t;

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl #(
  parameter int AW = 5
) (
  input  logic                   renValid,
  input  logic                   dstValid,
  input  logic [AW-1:0]          dstArch,
  input  logic                   anyFree,
  input  logic                   wbValid,
  input  logic                   freeValid,
  output rename_pkg::strobe_t    strb,
  output logic                   stall
);

  logic wantDst;

  // register 0 is never given a new physical home
  assign wantDst = renValid && dstValid && (dstArch != '0);

  always_comb begin
    stall        = wantDst && !anyFree;
    strb.allocEn = wantDst && anyFree;
    strb.wbEn    = wbValid;
    strb.freeEn  = freeValid;
  end

endmodule

// File: rtl/rename_datapath.sv
module rename_datapath #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64,
  parameter int AW        = 5,
  parameter int PW        = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  rename_pkg::strobe_t strb,
  input  logic [AW-1:0]       srcA,
  input  logic [AW-1:0]       srcB,
  input  logic [AW-1:0]       dstArch,
  input  logic [PW-1:0]       wbTag,
  input  logic [PW-1:0]       freeTag,
  output logic [PW-1:0]       physA,
  output logic                pendA,
  output logic [PW-1:0]       physB,
  output logic                pendB,
  output logic [PW-1:0]       dstPhys,
  output logic [PW-1:0]       prevPhys,
  output logic                anyFree
);

  logic [PHYS_REGS-1:0] freeBits;
  logic [PHYS_REGS-1:0] freeNext;
  logic [PW-1:0]        mapTab [ARCH_REGS];
  logic [ARCH_REGS-1:0] pendBits;
  logic [ARCH_REGS-1:0] dstHit;
  logic [ARCH_REGS-1:0] wbHit;
  logic [PW-1:0]        allocTag;

  // lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    allocTag = '0;
    anyFree  = 1'b0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (freeBits[i]) begin
        allocTag = PW'(i);
        anyFree  = 1'b1;
      end
    end
  end

  // per-entry match decode
  for (genvar g = 0; g < ARCH_REGS; g++) begin : gEntry
    assign dstHit[g] = strb.allocEn && (dstArch == AW'(g));
    assign wbHit[g]  = strb.wbEn && pendBits[g] && (mapTab[g] == wbTag);
  end

  // map table; a rename on the same entry overrides a writeback clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH_REGS; i++) mapTab[i] <= PW'(i);
      pendBits <= '0;
    end else begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        if (dstHit[i]) begin
          mapTab[i]   <= allocTag;
          pendBits[i] <= 1'b1;
        end else if (wbHit[i]) begin
          pendBits[i] <= 1'b0;
        end
      end
    end
  end

  // free list: clear the allocated bit, then set the released one
  always_comb begin
    freeNext = freeBits;
    if (strb.allocEn) freeNext[allocTag] = 1'b0;
    if (strb.freeEn)  freeNext[freeTag]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) freeBits[i] <= (i >= ARCH_REGS);
    end else begin
      freeBits <= freeNext;
    end
  end

  // source lookup with writeback bypass on the pending flag
  always_comb begin
    physA    = mapTab[srcA];
    physB    = mapTab[srcB];
    pendA    = (srcA != '0) && pendBits[srcA] && !(strb.wbEn && (wbTag == physA));
    pendB    = (srcB != '0) && pendBits[srcB] && !(strb.wbEn && (wbTag == physB));
    dstPhys  = allocTag;
    prevPhys = mapTab[dstArch];
  end

endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         renValid,
  input  logic [$clog2(ARCH_REGS)-1:0] srcA,
  input  logic [$clog2(ARCH_REGS)-1:0] srcB,
  input  logic                         dstValid,
  input  logic [$clog2(ARCH_REGS)-1:0] dstArch,
  output logic [$clog2(PHYS_REGS)-1:0] physA,
  output logic                         pendA,
  output logic [$clog2(PHYS_REGS)-1:0] physB,
  output logic                         pendB,
  output logic [$clog2(PHYS_REGS)-1:0] dstPhys,
  output logic [$clog2(PHYS_REGS)-1:0] prevPhys,
  output logic                         stall,
  input  logic                         wbValid,
  input  logic [$clog2(PHYS_REGS)-1:0] wbTag,
  input  logic                         freeValid,
  input  logic [$clog2(PHYS_REGS)-1:0] freeTag
);

  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);

  rename_pkg::strobe_t strb;
  logic                anyFree;

  rename_ctrl #(.AW(AW)) u_ctrl (
    .renValid (renValid),
    .dstValid (dstValid),
    .dstArch  (dstArch),
    .anyFree  (anyFree),
    .wbValid  (wbValid),
    .freeValid(freeValid),
    .strb     (strb),
    .stall    (stall)
  );

  rename_datapath #(
    .ARCH_REGS(ARCH_REGS),
    .PHYS_REGS(PHYS_REGS),
    .AW       (AW),
    .PW       (PW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .srcA    (srcA),
    .srcB    (srcB),
    .dstArch (dstArch),
    .wbTag   (wbTag),
    .freeTag (freeTag),
    .physA   (physA),
    .pendA   (pendA),
    .physB   (physB),
    .pendB   (pendB),
    .dstPhys (dstPhys),
    .prevPhys(prevPhys),
    .anyFree (anyFree)
  );

endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 64
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         renValid,
  input logic                         dstValid,
  input logic [$clog2(ARCH_REGS)-1:0] dstArch,
  input logic [$clog2(ARCH_REGS)-1:0] srcA,
  input logic                         pendA,
  input logic [$clog2(PHYS_REGS)-1:0] dstPhys,
  input logic                         stall,
  input logic                         freeValid,
  input logic [$clog2(PHYS_REGS)-1:0] freeTag,
  input logic [PHYS_REGS-1:0]         freeBits,
  input logic [ARCH_REGS-1:0]         pendBits
);

  logic alloc;
  assign alloc = renValid && dstValid && (dstArch != '0) && !stall;

  assert_stall_only_when_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> ($countones(freeBits) == 0));

  assert_stall_freezes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !freeValid) |=> $stable(freeBits));

  assert_alloc_from_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    alloc |-> freeBits[dstPhys]);

  assert_alloc_consumed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (alloc && !(freeValid && (freeTag == dstPhys))) |=> !freeBits[$past(dstPhys)]);

  assert_dst_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    alloc |=> pendBits[$past(dstArch)]);

  assert_x0_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == '0) |-> (!pendA && !pendBits[0]));

endmodule

bind reg_rename_unit rename_checker #(
  .ARCH_REGS(ARCH_REGS),
  .PHYS_REGS(PHYS_REGS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .renValid (renValid),
  .dstValid (dstValid),
  .dstArch  (dstArch),
  .srcA     (srcA),
  .pendA    (pendA),
  .dstPhys  (dstPhys),
  .stall    (stall),
  .freeValid(freeValid),
  .freeTag  (freeTag),
  .freeBits (u_dp.freeBits),
  .pendBits (u_dp.pendBits)
);

// File: tb/sim_reg_rename_unit.sv
`timescale 1ns/1ps
module sim_reg_rename_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       renValid = 1'b0, dstValid = 1'b0, wbValid = 1'b0, freeValid = 1'b0;
  logic [4:0] srcA = '0, srcB = '0, dstArch = '0;
  logic [5:0] wbTag = '0, freeTag = '0;
  logic [5:0] physA, physB, dstPhys, prevPhys;
  logic       pendA, pendB, stall;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int refMap [32];
  bit refPend [32];
  bit refFree [64];
  int prevQ [$];

  always #4 clk = ~clk;

  reg_rename_unit u0 (
    .clk(clk), .rstN(rstN), .renValid(renValid), .srcA(srcA), .srcB(srcB),
    .dstValid(dstValid), .dstArch(dstArch), .physA(physA), .pendA(pendA),
    .physB(physB), .pendB(pendB), .dstPhys(dstPhys), .prevPhys(prevPhys),
    .stall(stall), .wbValid(wbValid), .wbTag(wbTag), .freeValid(freeValid),
    .freeTag(freeTag)
  );

  function automatic int lowestFree();
    for (int i = 0; i < 64; i++) if (refFree[i]) return i;
    return -1;
  endfunction

  function automatic bit wantsDst();
    return renValid && dstValid && (dstArch != 0);
  endfunction

  function automatic bit expPend(int s);
    return (s != 0) && refPend[s] && !(wbValid && (refMap[s] == int'(wbTag)));
  endfunction

  // model advances on the rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin refMap[i] = i; refPend[i] = 0; end
      for (int i = 0; i < 64; i++) refFree[i] = (i >= 32);
      prevQ.delete();
    end else begin
      int nt;
      bit doAlloc;
      nt = lowestFree();
      doAlloc = wantsDst() && (nt >= 0);
      for (int a = 0; a < 32; a++) begin
        if (doAlloc && a == int'(dstArch)) begin
          prevQ.push_back(refMap[a]);
          refMap[a] = nt;
          refPend[a] = 1;
        end else if (wbValid && refMap[a] == int'(wbTag)) begin
          refPend[a] = 0;
        end
      end
      if (doAlloc) refFree[nt] = 0;
      if (freeValid) refFree[freeTag] = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive on the falling edge, compare just before the rising edge
  task automatic step(bit rv, int a, int b, bit dv, int d, bit wv, int wt, bit fv, int ft);
    int nt;
    @(negedge clk);
    renValid = rv; srcA = 5'(a); srcB = 5'(b); dstValid = dv; dstArch = 5'(d);
    wbValid = wv; wbTag = 6'(wt); freeValid = fv; freeTag = 6'(ft);
    #3;
    nt = lowestFree();
    chk(stall == (wantsDst() && nt < 0), "R8 stall", stall, wantsDst() && nt < 0);
    chk(int'(physA) == refMap[a], "R2 physA", physA, refMap[a]);
    chk(int'(physB) == refMap[b], "R2 physB", physB, refMap[b]);
    chk(pendA == expPend(a), "R5,R6 pendA", pendA, expPend(a));
    chk(pendB == expPend(b), "R5,R6 pendB", pendB, expPend(b));
    if (wantsDst() && nt >= 0) chk(int'(dstPhys) == nt, "R3 dstPhys", dstPhys, nt);
    if (dv) chk(int'(prevPhys) == refMap[d], "R4 prevPhys", prevPhys, refMap[d]);
  endtask

  task automatic idle(int a, int b);
    step(0, a, b, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    int ft;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset mapping
    idle(5, 31);
    chk(physA == 5 && physB == 31 && !pendA && !pendB, "R1 reset map", physA, 5);

    // R2, R3, R4: rename x1 reading x1
    step(1, 1, 2, 1, 1, 0, 0, 0, 0);
    chk(physA == 1, "R2 old source", physA, 1);
    chk(dstPhys == 32, "R1 first alloc", dstPhys, 32);
    chk(prevPhys == 1, "R4 prior map", prevPhys, 1);

    // R5: new mapping pending
    idle(1, 0);
    chk(physA == 32 && pendA, "R5 pending new tag", physA, 32);

    // R6: same-cycle bypass, then cleared
    step(0, 1, 0, 0, 0, 1, 32, 0, 0);
    chk(!pendA, "R6 bypass", pendA, 0);
    idle(1, 0);
    chk(!pendA, "R6 cleared", pendA, 0);

    // R7: rename wins over writeback of old tag
    step(1, 0, 0, 1, 2, 0, 0, 0, 0);
    step(1, 2, 0, 1, 2, 1, 33, 0, 0);
    chk(physA == 33 && !pendA, "R7 old tag lookup", physA, 33);
    idle(2, 0);
    chk(physA == 34 && pendA, "R7 rename wins", pendA, 1);

    // R10: destination x0 allocates nothing
    step(1, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(!stall && physA == 0 && !pendA, "R10 x0 source", physA, 0);
    step(1, 0, 0, 1, 3, 0, 0, 0, 0);
    chk(dstPhys == 35, "R10 no alloc for x0", dstPhys, 35);

    // R11: dstValid low changes nothing
    step(1, 0, 0, 0, 4, 0, 0, 0, 0);
    idle(4, 0);
    chk(physA == 4 && !pendA, "R11 no remap", physA, 4);
    step(0, 0, 0, 1, 4, 0, 0, 0, 0);
    idle(4, 0);
    chk(physA == 4, "R11 renValid low", physA, 4);

    // R8: exhaust 36..63 then stall
    for (int k = 0; k < 28; k++) step(1, 0, 0, 1, 8 + (k % 20), 0, 0, 0, 0);
    idle(5, 0);
    held = physA;
    step(1, 5, 0, 1, 5, 0, 0, 0, 0);
    chk(stall == 1, "R8 stall raised", stall, 1);
    idle(5, 0);
    chk(int'(physA) == held && !pendA, "R8 map unchanged", physA, held);

    // R9: freed tag usable only next cycle
    ft = prevQ.pop_front();
    step(1, 0, 0, 1, 6, 0, 0, 1, ft);
    chk(stall == 1, "R9 not same cycle", stall, 1);
    step(1, 0, 0, 1, 6, 0, 0, 0, 0);
    chk(!stall && int'(dstPhys) == ft, "R9 freed reuse", dstPhys, ft);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      bit fv;
      int f;
      fv = ($urandom % 2 == 0) && (prevQ.size() > 0);
      f = fv ? prevQ.pop_front() : 0;
      step($urandom % 4 != 0, $urandom % 32, $urandom % 32, $urandom % 3 != 0,
           $urandom % 32, $urandom % 2, refMap[$urandom % 32], fv, f);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule